// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits in an SDRAM controller next to the command sequencer and produces, one per clock, the column address of each data beat of a burst inside an already open page. When a read or write command is issued, the sequencer pulses the command strobe and presents the start column, the length code, the ordering choice and the write flag. From the next cycle on, the block emits the beat columns, a valid flag and a final-beat flag until the burst is done.

Two beat orderings are offered. Sequential ordering counts upward but wraps inside the aligned window that the burst length defines, so the bits above the window never change. Interleaved ordering forms each beat column as the start column XOR the beat number. A page-length burst walks through all 256 columns modulo 256 and runs until a stop request or a new command ends it. A new command received mid-burst drops what is left and restarts the burst. A single-write option cuts write bursts to one beat and leaves reads at their programmed length.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `beat_valid_o`, `last_o`, `stop_illegal_o` and `len_err_o` are all 0, and `col_o` is 0.
- R2: When `cmd_i` is high at a clock edge, the outputs in the following cycle show beat 0: `beat_valid_o` is 1 and `col_o` equals the `col_i` sampled with the command.
- R3: Length codes on `len_code_i` give 3'b000 one beat, 3'b001 two, 3'b010 four, 3'b011 eight and 3'b111 a page; a finite burst shows exactly that many consecutive valid beats, `last_o` is high on the final one only, and `beat_valid_o` is 0 in the cycle after it unless a new command was given.
- R4: With `interleave_i` = 0, beat k of a burst of length L has the column bits above the window (the low log2(L) bits) equal to the start column and the window bits equal to (start + k) mod L; no carry crosses out of the window.
- R5: With `interleave_i` = 1 and a finite length, beat k has column `col_i` XOR k.
- R6: With length code 3'b111, beat k has column (start + k) mod 256 whatever `interleave_i` is, beats continue past 256 with no end, and `last_o` stays 0.
- R7: A command given during a burst discards the rest of it; in the next cycle beat 0 of the new burst appears and the new burst runs its full programmed length.
- R8: `stop_i` high without `cmd_i` during a page-length burst makes `beat_valid_o` 0 in the next cycle.
- R9: `stop_i` high without `cmd_i` during a finite burst has no effect on the beats, and `stop_illegal_o` is 1 for one cycle in the next cycle.
- R10: With `single_wr_i` = 1, a command with `write_i` = 1 yields one beat with `last_o` high; a command with `write_i` = 0 keeps the programmed length.
- R11: Length codes 3'b100, 3'b101 and 3'b110 produce a one-beat burst and raise `len_err_o` for one cycle in the cycle of beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Read or write command strobe; a strobe during a burst restarts it |
| write_i | input | 1 | 1 for a write command, 0 for a read |
| col_i | input | 8 | Start column of the command |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 0 sequential ordering, 1 interleaved ordering |
| single_wr_i | input | 1 | 1 restricts write bursts to one beat |
| stop_i | input | 1 | Burst stop request |
| col_o | output | 8 | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one of a finite burst |
| stop_illegal_o | output | 1 | Pulse: a stop arrived during a finite burst |
| len_err_o | output | 1 | Pulse: the command used a reserved length code |

## Verification
The bench starts sequential bursts near a window edge (start 0x35 and page start 0xF0), where a design that lets the carry escape the window or wraps the page at the wrong width would alter the upper column bits. Interleaved bursts from an odd start catch a design that adds instead of XORs, and the page burst run with interleave requested catches one that applies XOR ordering to a page. Restarts mid-burst, stops in both finite and page mode, single-write on reads against writes, and reserved length codes target a controller that keeps the old beat count, obeys an illegal stop, shortens reads, or forgets to flag an unknown code.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int COL_W  = 8;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic [COL_W-1:0] mask;   // window size minus one
    logic             page;   // page-length burst
    logic             bad;    // reserved length code
  } len_cfg_t;

  // Translate a length code into a window mask.
  function automatic len_cfg_t decode_len(input logic [CODE_W-1:0] code);
    len_cfg_t c;
    c.mask = '0;
    c.page = 1'b0;
    c.bad  = 1'b0;
    if (code == {CODE_W{1'b1}}) begin
      c.mask = {COL_W{1'b1}};
      c.page = 1'b1;
    end else if (code[CODE_W-1] == 1'b0) begin
      c.mask = COL_W'((1 << code[1:0]) - 1);
    end else begin
      c.bad = 1'b1;
    end
    return c;
  endfunction

  // Column of a beat: window bits stepped or XORed, upper bits held.
  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] base,
                                                input logic [COL_W-1:0] idx,
                                                input logic [COL_W-1:0] mask,
                                                input logic             xor_order);
    logic [COL_W-1:0] low;
    if (xor_order) low = (base ^ idx) & mask;
    else           low = (base + idx) & mask;
    return (base & ~mask) | low;
  endfunction
endpackage

// File: rtl/bc_len_decode.sv
module bc_len_decode
  import burst_col_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic [CODE_W-1:0] len_code,
  input  logic              write,
  input  logic              single_wr,
  input  logic              interleave,
  output logic [CW-1:0]     mask,
  output logic              page,
  output logic              bad,
  output logic              xor_order
);
  len_cfg_t cfg;
  logic     one_shot;

  always_comb begin
    cfg      = decode_len(len_code);
    one_shot = write & single_wr;
    bad      = cfg.bad;
    if (one_shot) begin
      mask = '0;
      page = 1'b0;
    end else begin
      mask = CW'(cfg.mask);
      page = cfg.page;
    end
    xor_order = interleave & ~page;
  end
endmodule

// File: rtl/bc_beat_ctrl.sv
module bc_beat_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd,
  input  logic [CW-1:0] col,
  input  logic [CW-1:0] mask_in,
  input  logic          page_in,
  input  logic          xor_in,
  input  logic          stop,
  output logic          active,
  output logic [CW-1:0] base_q,
  output logic [CW-1:0] idx_q,
  output logic [CW-1:0] mask_q,
  output logic          page_q,
  output logic          xor_q,
  output logic          final_beat,
  output logic          stop_hit,
  output logic          stop_bad
);
  assign final_beat = active & ~page_q & (idx_q == mask_q);
  assign stop_hit   = stop & ~cmd & active & page_q;
  assign stop_bad   = stop & ~cmd & active & ~page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
      xor_q  <= 1'b0;
    end else if (cmd) begin
      active <= 1'b1;
      base_q <= col;
      idx_q  <= '0;
      mask_q <= mask_in;
      page_q <= page_in;
      xor_q  <= xor_in;
    end else if (stop_hit) begin
      active <= 1'b0;
    end else if (active) begin
      if (final_beat) active <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/bc_addr_form.sv
module bc_addr_form
  import burst_col_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic          active,
  input  logic          final_beat,
  input  logic [CW-1:0] base,
  input  logic [CW-1:0] idx,
  input  logic [CW-1:0] mask,
  input  logic          xor_order,
  output logic [CW-1:0] col,
  output logic          valid,
  output logic          last
);
  always_comb begin
    col   = active ? CW'(beat_col(COL_W'(base), COL_W'(idx), COL_W'(mask), xor_order)) : '0;
    valid = active;
    last  = final_beat;
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_i,
  input  logic              write_i,
  input  logic [CW-1:0]     col_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              interleave_i,
  input  logic              single_wr_i,
  input  logic              stop_i,
  output logic [CW-1:0]     col_o,
  output logic              beat_valid_o,
  output logic              last_o,
  output logic              stop_illegal_o,
  output logic              len_err_o
);
  logic [CW-1:0] dec_mask;
  logic          dec_page, dec_bad, dec_xor;
  logic          active;
  logic [CW-1:0] base_q, idx_q, mask_q;
  logic          page_q, xor_q;
  logic          final_beat, stop_hit, stop_bad;

  bc_len_decode #(.CW(CW)) u_dec (
    .len_code  (len_code_i),
    .write     (write_i),
    .single_wr (single_wr_i),
    .interleave(interleave_i),
    .mask      (dec_mask),
    .page      (dec_page),
    .bad       (dec_bad),
    .xor_order (dec_xor)
  );

  bc_beat_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd_i),
    .col       (col_i),
    .mask_in   (dec_mask),
    .page_in   (dec_page),
    .xor_in    (dec_xor),
    .stop      (stop_i),
    .active    (active),
    .base_q    (base_q),
    .idx_q     (idx_q),
    .mask_q    (mask_q),
    .page_q    (page_q),
    .xor_q     (xor_q),
    .final_beat(final_beat),
    .stop_hit  (stop_hit),
    .stop_bad  (stop_bad)
  );

  bc_addr_form #(.CW(CW)) u_form (
    .active    (active),
    .final_beat(final_beat),
    .base      (base_q),
    .idx       (idx_q),
    .mask      (mask_q),
    .xor_order (xor_q),
    .col       (col_o),
    .valid     (beat_valid_o),
    .last      (last_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_illegal_o <= 1'b0;
      len_err_o      <= 1'b0;
    end else begin
      stop_illegal_o <= stop_bad;
      len_err_o      <= cmd_i & dec_bad;
    end
  end
endmodule

// File: rtl/burst_col_gen_checker.sv
module burst_col_gen_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_i,
  input logic          stop_i,
  input logic [CW-1:0] col_i,
  input logic [CW-1:0] col_o,
  input logic          beat_valid_o,
  input logic          last_o,
  input logic          stop_illegal_o,
  input logic [CW-1:0] mask_q,
  input logic          page_q,
  input logic          xor_q
);
  // R2, R7: a command always shows beat 0 at its start column next cycle
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i |=> (beat_valid_o && col_o == $past(col_i)));

  // R3: final beat flag only on a valid beat, and the burst ends after it
  p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> beat_valid_o);
  p_end_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !cmd_i) |=> !beat_valid_o);

  // R4: sequential finite burst steps inside its window, upper bits held
  p_seq_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !last_o && !cmd_i && !stop_i && !page_q && !xor_q) |=>
      (((col_o & ~mask_q) == ($past(col_o) & ~$past(mask_q))) &&
       ((col_o & mask_q) == (($past(col_o) + 1'b1) & mask_q))));

  // R6: page burst never flags a final beat
  p_page_no_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && page_q) |-> !last_o);

  // R8: stop ends a page burst
  p_page_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !cmd_i && beat_valid_o && page_q) |=> !beat_valid_o);

  // R9: stop in a finite burst is flagged and does not end the beats early
  p_bad_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !cmd_i && beat_valid_o && !page_q && !last_o) |=>
      (stop_illegal_o && beat_valid_o));
endmodule

bind burst_col_gen burst_col_gen_checker #(.CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_i         (cmd_i),
  .stop_i        (stop_i),
  .col_i         (col_i),
  .col_o         (col_o),
  .beat_valid_o  (beat_valid_o),
  .last_o        (last_o),
  .stop_illegal_o(stop_illegal_o),
  .mask_q        (mask_q),
  .page_q        (page_q),
  .xor_q         (xor_q)
);

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_i = 1'b0, write_i = 1'b0, interleave_i = 1'b0;
  logic       single_wr_i = 1'b0, stop_i = 1'b0;
  logic [7:0] col_i = '0;
  logic [2:0] len_code_i = '0;
  logic [7:0] col_o;
  logic       beat_valid_o, last_o, stop_illegal_o, len_err_o;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  burst_col_gen dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .write_i(write_i), .col_i(col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .single_wr_i(single_wr_i),
    .stop_i(stop_i), .col_o(col_o), .beat_valid_o(beat_valid_o), .last_o(last_o),
    .stop_illegal_o(stop_illegal_o), .len_err_o(len_err_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference column: window offset advanced modulo length, or XOR order
  function automatic logic [7:0] ref_col(input int base, input int k, input int len,
                                         input bit xr);
    int off;
    if (xr && len < 256) return 8'(base ^ k);
    off = base % len;
    return 8'(base - off + (off + k) % len);
  endfunction

  // Called at a negedge; returns at the negedge where beat 0 is visible
  task automatic issue(input logic [7:0] c, input logic [2:0] code, input bit il,
                       input bit wr, input bit sw);
    cmd_i = 1'b1; col_i = c; len_code_i = code; interleave_i = il;
    write_i = wr; single_wr_i = sw;
    @(negedge clk);
    cmd_i = 1'b0;
  endtask

  task automatic follow(input int base, input int len, input bit xr, input int k0,
                        input int k1, input bit finite, input string req);
    for (int k = k0; k <= k1; k++) begin
      if (k > k0) @(negedge clk);
      check(beat_valid_o == 1'b1, req, "valid", beat_valid_o, 1);
      check(col_o == ref_col(base, k, len, xr), req, "column", col_o, ref_col(base, k, len, xr));
      check(last_o == (finite && k == len - 1), req, "last", last_o, finite && k == len - 1);
    end
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk);
    check(beat_valid_o == 1'b0, req, "idle after burst", beat_valid_o, 0);
  endtask

  task automatic t_reset;
    check(beat_valid_o == 0, "R1", "valid", beat_valid_o, 0);
    check(last_o == 0, "R1", "last", last_o, 0);
    check(stop_illegal_o == 0 && len_err_o == 0, "R1", "flags", {stop_illegal_o, len_err_o}, 0);
    check(col_o == 0, "R1", "column", col_o, 0);
  endtask

  // R2 R3 R4: each finite length, sequential, start near a window edge
  task automatic t_lengths;
    for (int c = 0; c < 4; c++) begin
      issue(8'h35, 3'(c), 1'b0, 1'b0, 1'b0);
      check(col_o == 8'h35, "R2", "beat 0 column", col_o, 8'h35);
      follow(8'h35, 1 << c, 1'b0, 0, (1 << c) - 1, 1'b1, "R3_R4");
      expect_idle("R3");
    end
    issue(8'hFE, 3'd3, 1'b0, 1'b1, 1'b0);
    follow(8'hFE, 8, 1'b0, 0, 7, 1'b1, "R4");
    expect_idle("R4");
  endtask

  task automatic t_interleave;
    issue(8'h5D, 3'd3, 1'b1, 1'b0, 1'b0);
    follow(8'h5D, 8, 1'b1, 0, 7, 1'b1, "R5");
    expect_idle("R5");
    issue(8'hA6, 3'd2, 1'b1, 1'b1, 1'b0);
    follow(8'hA6, 4, 1'b1, 0, 3, 1'b1, "R5");
    expect_idle("R5");
  endtask

  // R6 R8: page burst with interleave requested, wraps, then stopped
  task automatic t_page;
    issue(8'hF0, 3'd7, 1'b1, 1'b0, 1'b0);
    follow(8'hF0, 256, 1'b0, 0, 299, 1'b0, "R6");
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check(beat_valid_o == 1'b0, "R8", "stopped", beat_valid_o, 0);
    check(stop_illegal_o == 1'b0, "R8", "no illegal flag", stop_illegal_o, 0);
  endtask

  task automatic t_restart;
    issue(8'h10, 3'd3, 1'b0, 1'b0, 1'b0);
    follow(8'h10, 8, 1'b0, 0, 2, 1'b1, "R7");
    issue(8'h47, 3'd2, 1'b1, 1'b1, 1'b0);
    follow(8'h47, 4, 1'b1, 0, 3, 1'b1, "R7");
    expect_idle("R7");
  endtask

  task automatic t_bad_stop;
    issue(8'h22, 3'd3, 1'b0, 1'b0, 1'b0);
    follow(8'h22, 8, 1'b0, 0, 2, 1'b1, "R9");
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check(stop_illegal_o == 1'b1, "R9", "illegal flag", stop_illegal_o, 1);
    follow(8'h22, 8, 1'b0, 3, 7, 1'b1, "R9");
    check(stop_illegal_o == 1'b0, "R9", "flag one cycle", stop_illegal_o, 0);
    expect_idle("R9");
  endtask

  task automatic t_single_write;
    issue(8'h63, 3'd3, 1'b0, 1'b1, 1'b1);
    follow(8'h63, 1, 1'b0, 0, 0, 1'b1, "R10");
    expect_idle("R10");
    issue(8'h63, 3'd3, 1'b0, 1'b0, 1'b1);
    follow(8'h63, 8, 1'b0, 0, 7, 1'b1, "R10");
    expect_idle("R10");
  endtask

  task automatic t_reserved;
    for (int c = 4; c < 7; c++) begin
      issue(8'h9B, 3'(c), 1'b0, 1'b0, 1'b0);
      check(len_err_o == 1'b1, "R11", "error flag", len_err_o, 1);
      follow(8'h9B, 1, 1'b0, 0, 0, 1'b1, "R11");
      @(negedge clk);
      check(beat_valid_o == 1'b0, "R11", "one beat only", beat_valid_o, 0);
      check(len_err_o == 1'b0, "R11", "flag one cycle", len_err_o, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_lengths();
    t_interleave();
    t_page();
    t_restart();
    t_bad_stop();
    t_single_write();
    t_reserved();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule